// File: doc/BRIEF.md
# Block-Count Data Transfer Sequencer

This block moves data for a card data command between a 16-bit word FIFO and a byte-wide card data port. Software programs a block length and a block count, each written as the wanted value minus one. It then chooses a direction and raises the transfer-active input. In receive mode the sequencer takes card bytes and packs them into FIFO words. In transmit mode it takes FIFO words and unpacks them into card bytes. Two live counters track the bytes left in the current block and the blocks left in the transfer. When the last byte of the last block moves, both counters reload on their own and a done status bit is set.

All data paths use valid/ready handshakes. A byte or word moves in a cycle only when both valid and ready are high at the rising clock edge. A source keeps its valid and data steady until the transfer happens. Back-pressure works in two ways. The FIFO may hold push_ready low, or report a fill level above the almost-full threshold, and the card side stalls. The card may hold card_tx_ready low, or leave card_rx_valid low, and the word side stalls. A cycle that carries a register write moves no data.

Top module: `mmc_block_sequencer`

## Requirements
- R1: A write to the block-length register with value v (11 bits) sets the length to v+1 (1 to 2048). In the same cycle it loads the byte counter with that value. blen_count always reads back the live byte counter.
- R2: A write to the block-count register with value v sets the count to v+1. It loads nblk_count with v+1 and reloads the byte counter from the block length. If both registers are written in one cycle, the new length is used. No data moves in a write cycle.
- R3: Each FIFO word holds two bytes. Bits 7:0 are sent first, and bits 15:8 are sent only if the byte counter is still non-zero after the first byte. An odd final byte of a block fills a word alone: in receive mode its upper byte is zero, and in transmit mode the upper byte is skipped.
- R4: In receive mode (xfer_dir=1) no new word is started while fifo_count exceeds af_level. A word already started still takes its second byte. A completed word is held stable on push_data with push_valid high until push_ready.
- R5: In transmit mode (xfer_dir=0) a word is popped only when no word is held. A byte offered on card_tx_data stays stable until card_tx_ready.
- R6: When the byte counter goes from 1 to 0, the block counter decrements and the byte counter reloads from the block length.
- R7: When the last byte of the final block moves, nblk_count reloads from the programmed count and xfer_done goes high. The sequencer then accepts no data until transfer-active falls and rises again. That rising edge clears xfer_done.
- R8: A transfer starts on a rising edge of xfer_active, and at most one byte moves per clock. While xfer_active is low, the counters and the held data do not change, and no handshake is offered.
- R9: After reset both counters read 0, xfer_done is 0, and no valid or ready output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blen_wr | input | 1 | Block-length register write strobe |
| blen_wdata | input | 11 | Block length minus one |
| nblk_wr | input | 1 | Block-count register write strobe |
| nblk_wdata | input | 11 | Block count minus one |
| xfer_dir | input | 1 | 1 = receive from card, 0 = transmit to card |
| xfer_active | input | 1 | Data command active |
| af_level | input | 5 | FIFO almost-full threshold (in words) |
| fifo_count | input | 6 | Current FIFO fill level (in words) |
| push_valid | output | 1 | Packed word ready for the FIFO |
| push_ready | input | 1 | FIFO accepts the word |
| push_data | output | 16 | Packed word |
| pop_valid | input | 1 | FIFO has a word |
| pop_ready | output | 1 | Sequencer takes the word |
| pop_data | input | 16 | Word from the FIFO |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_ready | output | 1 | Sequencer takes the card byte |
| card_rx_data | input | 8 | Card byte |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_ready | input | 1 | Card takes the byte |
| card_tx_data | output | 8 | Byte to the card |
| blen_count | output | 12 | Live byte counter |
| nblk_count | output | 12 | Live block counter |
| xfer_done | output | 1 | Transfer-done status bit |

## Verification
The hardest situation to reach is a receive word whose first byte has been taken when the FIFO level then rises above the almost-full threshold. The second byte must still be taken, and only the next word may stall. The stimulus fixes fifo_count directly at the bench: it holds the level above the threshold, lowers it for exactly one byte, and raises it again before the upper byte arrives. The other two key cases are a transfer dropped in the middle of a block and one-byte blocks, where every word is an odd final word. Those are reached through directed runs and the vector table.

// File: rtl/mmc_seq_pkg.sv
`timescale 1ns/1ps
package mmc_seq_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } seq_dir_e;
endpackage

// File: rtl/mmc_seq_counters.sv
`timescale 1ns/1ps
module mmc_seq_counters #(
  parameter int LEN_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               len_wr,
  input  logic [LEN_W-1:0]   len_wdata,
  input  logic               cnt_wr,
  input  logic [LEN_W-1:0]   cnt_wdata,
  input  logic               byte_step,
  output logic [LEN_W:0]     byte_cnt,
  output logic [LEN_W:0]     blk_cnt,
  output logic               last_in_block,
  output logic               xfer_end
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] len_q, nlen_q, byte_q, blk_q;
  logic [CNT_W-1:0] len_new, nlen_new;
  logic             last_block, any_wr;

  assign len_new  = CNT_W'(len_wdata) + CNT_W'(1);
  assign nlen_new = CNT_W'(cnt_wdata) + CNT_W'(1);
  assign any_wr   = len_wr | cnt_wr;

  assign last_in_block = (byte_q == CNT_W'(1));
  assign last_block    = (blk_q == CNT_W'(1));
  assign xfer_end      = byte_step & ~any_wr & last_in_block & last_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      nlen_q <= '0;
      byte_q <= '0;
      blk_q  <= '0;
    end else begin
      if (len_wr) begin
        len_q  <= len_new;
        byte_q <= len_new;
      end
      if (cnt_wr) begin
        nlen_q <= nlen_new;
        blk_q  <= nlen_new;
        byte_q <= len_wr ? len_new : len_q;
      end
      if (!any_wr && byte_step) begin
        if (last_in_block) begin
          byte_q <= len_q;
          blk_q  <= last_block ? nlen_q : blk_q - CNT_W'(1);
        end else begin
          byte_q <= byte_q - CNT_W'(1);
        end
      end
    end
  end

  assign byte_cnt = byte_q;
  assign blk_cnt  = blk_q;
endmodule

// File: rtl/mmc_seq_rx_pack.sv
`timescale 1ns/1ps
module mmc_seq_rx_pack #(
  parameter int BYTE_W = 8,
  parameter int LVL_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                flush,
  input  logic                last_in_block,
  input  logic [LVL_W:0]      fifo_count,
  input  logic [LVL_W-1:0]    af_level,
  input  logic                card_valid,
  input  logic [BYTE_W-1:0]   card_data,
  output logic                card_ready,
  output logic                byte_fire,
  output logic                push_valid,
  input  logic                push_ready,
  output logic [2*BYTE_W-1:0] push_data
);
  localparam int WORD_W = 2 * BYTE_W;

  logic              lo_have, pend;
  logic [WORD_W-1:0] word_q;
  logic              room;

  assign room       = (fifo_count <= {1'b0, af_level});
  assign card_ready = enable & ~pend & (lo_have | room);
  assign byte_fire  = card_valid & card_ready;
  assign push_valid = pend;
  assign push_data  = word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_have <= 1'b0;
      pend    <= 1'b0;
      word_q  <= '0;
    end else if (flush) begin
      lo_have <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (pend && push_ready) pend <= 1'b0;
      if (byte_fire) begin
        if (!lo_have) begin
          word_q <= {{BYTE_W{1'b0}}, card_data};
          if (last_in_block) pend <= 1'b1;
          else               lo_have <= 1'b1;
        end else begin
          word_q[WORD_W-1:BYTE_W] <= card_data;
          lo_have <= 1'b0;
          pend    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mmc_seq_tx_unpack.sv
`timescale 1ns/1ps
module mmc_seq_tx_unpack #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                flush,
  input  logic                last_in_block,
  input  logic                pop_valid,
  input  logic [2*BYTE_W-1:0] pop_data,
  output logic                pop_ready,
  output logic                tx_valid,
  output logic [BYTE_W-1:0]   tx_data,
  input  logic                tx_ready,
  output logic                byte_fire
);
  localparam int WORD_W = 2 * BYTE_W;

  logic              hold_v, hold_hi;
  logic [WORD_W-1:0] hold_w;

  assign pop_ready = enable & ~hold_v;
  assign tx_valid  = enable & hold_v;
  assign tx_data   = hold_hi ? hold_w[WORD_W-1:BYTE_W] : hold_w[BYTE_W-1:0];
  assign byte_fire = tx_valid & tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v  <= 1'b0;
      hold_hi <= 1'b0;
      hold_w  <= '0;
    end else if (flush) begin
      hold_v  <= 1'b0;
      hold_hi <= 1'b0;
    end else if (pop_valid && pop_ready) begin
      hold_v  <= 1'b1;
      hold_hi <= 1'b0;
      hold_w  <= pop_data;
    end else if (byte_fire) begin
      if (!hold_hi && !last_in_block) begin
        hold_hi <= 1'b1;
      end else begin
        hold_v  <= 1'b0;
        hold_hi <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mmc_block_sequencer.sv
`timescale 1ns/1ps
module mmc_block_sequencer
  import mmc_seq_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int BYTE_W = 8,
  parameter int LVL_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blen_wr,
  input  logic [LEN_W-1:0]    blen_wdata,
  input  logic                nblk_wr,
  input  logic [LEN_W-1:0]    nblk_wdata,
  input  logic                xfer_dir,
  input  logic                xfer_active,
  input  logic [LVL_W-1:0]    af_level,
  input  logic [LVL_W:0]      fifo_count,
  output logic                push_valid,
  input  logic                push_ready,
  output logic [2*BYTE_W-1:0] push_data,
  input  logic                pop_valid,
  output logic                pop_ready,
  input  logic [2*BYTE_W-1:0] pop_data,
  input  logic                card_rx_valid,
  output logic                card_rx_ready,
  input  logic [BYTE_W-1:0]   card_rx_data,
  output logic                card_tx_valid,
  input  logic                card_tx_ready,
  output logic [BYTE_W-1:0]   card_tx_data,
  output logic [LEN_W:0]      blen_count,
  output logic [LEN_W:0]      nblk_count,
  output logic                xfer_done
);
  logic active_q, armed_q, done_q;
  logic start, running, rx_en, tx_en;
  logic rx_fire, tx_fire, last_in_block, xfer_end;

  assign start   = xfer_active & ~active_q;
  assign running = armed_q & xfer_active & ~start & ~blen_wr & ~nblk_wr;
  assign rx_en   = running & (seq_dir_e'(xfer_dir) == DIR_RX);
  assign tx_en   = running & (seq_dir_e'(xfer_dir) == DIR_TX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= xfer_active;
      if (start) begin
        armed_q <= 1'b1;
        done_q  <= 1'b0;
      end else if (xfer_end) begin
        armed_q <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  mmc_seq_counters #(.LEN_W(LEN_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .len_wr       (blen_wr),
    .len_wdata    (blen_wdata),
    .cnt_wr       (nblk_wr),
    .cnt_wdata    (nblk_wdata),
    .byte_step    (rx_fire | tx_fire),
    .byte_cnt     (blen_count),
    .blk_cnt      (nblk_count),
    .last_in_block(last_in_block),
    .xfer_end     (xfer_end)
  );

  mmc_seq_rx_pack #(.BYTE_W(BYTE_W), .LVL_W(LVL_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (rx_en),
    .flush        (start),
    .last_in_block(last_in_block),
    .fifo_count   (fifo_count),
    .af_level     (af_level),
    .card_valid   (card_rx_valid),
    .card_data    (card_rx_data),
    .card_ready   (card_rx_ready),
    .byte_fire    (rx_fire),
    .push_valid   (push_valid),
    .push_ready   (push_ready),
    .push_data    (push_data)
  );

  mmc_seq_tx_unpack #(.BYTE_W(BYTE_W)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (tx_en),
    .flush        (start),
    .last_in_block(last_in_block),
    .pop_valid    (pop_valid),
    .pop_data     (pop_data),
    .pop_ready    (pop_ready),
    .tx_valid     (card_tx_valid),
    .tx_data      (card_tx_data),
    .tx_ready     (card_tx_ready),
    .byte_fire    (tx_fire)
  );

  assign xfer_done = done_q;
endmodule

// File: rtl/mmc_block_sequencer_chk.sv
`timescale 1ns/1ps
module mmc_block_sequencer_chk #(
  parameter int LEN_W  = 11,
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                blen_wr,
  input logic [LEN_W-1:0]    blen_wdata,
  input logic                nblk_wr,
  input logic [LEN_W-1:0]    nblk_wdata,
  input logic                xfer_active,
  input logic                push_valid,
  input logic                push_ready,
  input logic [2*BYTE_W-1:0] push_data,
  input logic                card_rx_ready,
  input logic                card_tx_valid,
  input logic                card_tx_ready,
  input logic [BYTE_W-1:0]   card_tx_data,
  input logic [LEN_W:0]      blen_count,
  input logic [LEN_W:0]      nblk_count,
  input logic                xfer_done
);
  localparam int CNT_W = LEN_W + 1;

  p_blen_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    blen_wr |=> blen_count == CNT_W'($past(blen_wdata)) + CNT_W'(1));

  p_nblk_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nblk_wr |=> nblk_count == CNT_W'($past(nblk_wdata)) + CNT_W'(1));

  p_push_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_data));

  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid && !card_tx_ready |=>
      (!card_tx_valid || $stable(card_tx_data)));

  p_one_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_rx_ready && card_tx_valid));

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active && !blen_wr && !nblk_wr |=>
      $stable(blen_count) && $stable(nblk_count));

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> $past(nblk_count) == CNT_W'(1));
endmodule

bind mmc_block_sequencer mmc_block_sequencer_chk #(
  .LEN_W (LEN_W),
  .BYTE_W(BYTE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .blen_wr      (blen_wr),
  .blen_wdata   (blen_wdata),
  .nblk_wr      (nblk_wr),
  .nblk_wdata   (nblk_wdata),
  .xfer_active  (xfer_active),
  .push_valid   (push_valid),
  .push_ready   (push_ready),
  .push_data    (push_data),
  .card_rx_ready(card_rx_ready),
  .card_tx_valid(card_tx_valid),
  .card_tx_ready(card_tx_ready),
  .card_tx_data (card_tx_data),
  .blen_count   (blen_count),
  .nblk_count   (nblk_count),
  .xfer_done    (xfer_done)
);

// File: tb/mmc_block_sequencer_test.sv
`timescale 1ns/1ps
module mmc_block_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // [31] dir (1=rx), [30] stall, [29:24] len-1, [23:16] blocks-1, [15:8] seed, [7:0] expected words
  localparam logic [31:0] VEC [NVEC] = '{
    32'h8301_1104, 32'hC402_2309, 32'h0201_3504,
    32'h4502_4709, 32'hC003_5904, 32'h0002_6B03
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic blen_wr = 0, nblk_wr = 0, xfer_dir = 0, xfer_active = 0;
  logic [10:0] blen_wdata = 0, nblk_wdata = 0;
  logic [4:0] af_level = 5'd31;
  logic [5:0] fifo_count = 0;
  logic push_valid, push_ready = 0, pop_ready, pop_valid = 0;
  logic [15:0] push_data, pop_data = 0;
  logic card_rx_valid = 0, card_rx_ready, card_tx_valid, card_tx_ready = 0;
  logic [7:0] card_rx_data = 0, card_tx_data;
  logic [11:0] blen_count, nblk_count;
  logic xfer_done;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmc_block_sequencer uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_blen(input int v);
    @(negedge clk); blen_wr = 1; blen_wdata = 11'(v);
    @(negedge clk); blen_wr = 0;
  endtask

  task automatic wr_nblk(input int v);
    @(negedge clk); nblk_wr = 1; nblk_wdata = 11'(v);
    @(negedge clk); nblk_wr = 0;
  endtask

  task automatic idle_ports();
    card_rx_valid = 0; card_tx_ready = 0; pop_valid = 0;
    push_ready = 0; fifo_count = 0;
  endtask

  task automatic run_vec(input logic [31:0] e);
    logic [7:0] eb [64];
    logic [15:0] ew [64];
    bit dir, stall, finished;
    int len, nb_blk, nb, nw, k, bi, wi, occ;
    logic [7:0] hi;
    dir = e[31]; stall = e[30];
    len = int'(e[29:24]) + 1; nb_blk = int'(e[23:16]) + 1;
    nb = len * nb_blk;
    for (int i = 0; i < 64; i++) eb[i] = 8'(i * 7) + e[15:8];
    k = 0; nw = 0;
    for (int b = 0; b < nb_blk; b++)
      for (int i = 0; i < len; i += 2) begin
        hi = (i + 1 < len) ? eb[k+1] : (dir ? 8'h00 : 8'hEE);
        ew[nw] = {hi, eb[k]};
        nw++;
        k += (i + 1 < len) ? 2 : 1;
      end
    wr_blen(len - 1);
    wr_nblk(nb_blk - 1);
    xfer_dir = dir; af_level = stall ? 5'd1 : 5'd31;
    bi = 0; wi = 0; occ = 0; finished = 0;
    @(negedge clk); xfer_active = 1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (xfer_done && (dir ? (wi == nw) : (bi == nb))) begin finished = 1; break; end
      fifo_count    = 6'(occ);
      card_rx_valid = dir && (bi < nb) && (!stall || (c % 3) != 1);
      card_rx_data  = eb[bi % 64];
      push_ready    = !stall || (c % 2 == 0);
      pop_valid     = !dir && (wi < nw) && (!stall || (c % 4) != 0);
      pop_data      = ew[wi % 64];
      card_tx_ready = !dir && (!stall || (c % 3) != 1);
      #1;
      if (card_rx_valid && card_rx_ready) bi++;
      if (push_valid && push_ready) begin
        chk(push_data == ew[wi % 64], "R3", "packed word", push_data, ew[wi % 64]);
        wi++; occ++;
      end
      if (pop_valid && pop_ready) wi++;
      if (card_tx_valid && card_tx_ready) begin
        chk(card_tx_data == eb[bi % 64], "R3", "card byte order", card_tx_data, eb[bi % 64]);
        bi++;
      end
      if (!stall) occ = 0;
      else if ((c % 5) == 0 && occ > 0) occ--;
    end
    chk(finished, "R7", "transfer completed", int'(finished), 1);
    chk(wi == int'(e[7:0]), "R3", "word count", wi, int'(e[7:0]));
    chk(bi == nb, "R6", "byte count", bi, nb);
    chk(blen_count == 12'(len), "R6", "byte counter reloaded", blen_count, len);
    chk(nblk_count == 12'(nb_blk), "R7", "block counter reloaded", nblk_count, nb_blk);
    chk(xfer_done == 1'b1, "R7", "done bit", xfer_done, 1);
    idle_ports();
    xfer_active = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(blen_count == 0, "R9", "blen after reset", blen_count, 0);
    chk(nblk_count == 0, "R9", "nblk after reset", nblk_count, 0);
    chk(xfer_done == 0, "R9", "done after reset", xfer_done, 0);
    chk(!push_valid && !card_tx_valid && !card_rx_ready && !pop_ready, "R9",
        "handshakes idle", {push_valid, card_tx_valid, card_rx_ready, pop_ready}, 0);

    // vector table: full transfers, both directions, with and without stalls
    for (int v = 0; v < NVEC; v++) run_vec(VEC[v]);

    // R1 length boundaries
    wr_blen(2047);
    chk(blen_count == 12'd2048, "R1", "max length", blen_count, 2048);
    wr_blen(0);
    chk(blen_count == 12'd1, "R1", "min length", blen_count, 1);

    // R2 both writes in one cycle
    @(negedge clk); blen_wr = 1; blen_wdata = 11'd5; nblk_wr = 1; nblk_wdata = 11'd9;
    @(negedge clk); blen_wr = 0; nblk_wr = 0;
    chk(blen_count == 12'd6, "R2", "joint write length", blen_count, 6);
    chk(nblk_count == 12'd10, "R2", "joint write count", nblk_count, 10);

    // R8 stop mid-block freezes counters
    wr_blen(7); wr_nblk(0);
    xfer_dir = 0; pop_valid = 1; pop_data = 16'hA1B2; card_tx_ready = 1;
    @(negedge clk); xfer_active = 1;
    n = 0;
    while (n < 3) begin @(negedge clk); #1; if (card_tx_valid && card_tx_ready) n++; end
    @(negedge clk); xfer_active = 0; card_tx_ready = 0; pop_valid = 0;
    repeat (4) @(negedge clk);
    chk(blen_count == 12'd5, "R8", "frozen byte counter", blen_count, 5);
    chk(nblk_count == 12'd1, "R8", "frozen block counter", nblk_count, 1);
    chk(card_tx_valid == 0, "R8", "no byte offered while inactive", card_tx_valid, 0);
    // R2 block-count write reloads byte counter
    wr_nblk(1);
    chk(blen_count == 12'd8, "R2", "byte counter reload", blen_count, 8);
    chk(nblk_count == 12'd2, "R2", "block counter load", nblk_count, 2);

    // R4 almost-full pause, incl. the mid-word case
    wr_blen(3); wr_nblk(0);
    xfer_dir = 1; af_level = 5'd2; fifo_count = 6'd3; push_ready = 0;
    card_rx_valid = 1; card_rx_data = 8'h11;
    @(negedge clk); xfer_active = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(card_rx_ready == 0, "R4", "paused above threshold", card_rx_ready, 0);
    end
    chk(blen_count == 12'd4, "R4", "no byte taken while paused", blen_count, 4);
    @(negedge clk); fifo_count = 6'd2; #1;
    chk(card_rx_ready == 1, "R4", "resumes at threshold", card_rx_ready, 1);
    @(negedge clk); fifo_count = 6'd5; card_rx_data = 8'h22; #1;
    chk(card_rx_ready == 1, "R4", "second byte taken above threshold", card_rx_ready, 1);
    @(negedge clk);
    chk(blen_count == 12'd2, "R6", "two bytes counted", blen_count, 2);
    chk(push_valid && push_data == 16'h2211, "R3", "low byte first", push_data, 16'h2211);
    @(negedge clk); #1;
    chk(push_valid && push_data == 16'h2211 && !card_rx_ready, "R4", "word held",
        push_data, 16'h2211);
    @(negedge clk); push_ready = 1;
    @(negedge clk); idle_ports(); xfer_active = 0;
    @(negedge clk);

    // R7 odd single byte, then ignore input after done
    wr_blen(0); wr_nblk(0);
    xfer_dir = 1; af_level = 5'd31; push_ready = 1;
    card_rx_valid = 1; card_rx_data = 8'h5C;
    @(negedge clk); xfer_active = 1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (push_valid && push_ready) begin
        n++;
        chk(push_data == 16'h005C, "R3", "odd byte alone", push_data, 16'h005C);
      end
    end
    chk(n == 1, "R7", "exactly one word after done", n, 1);
    chk(card_rx_ready == 0, "R7", "no bytes taken after done", card_rx_ready, 0);
    chk(blen_count == 1 && nblk_count == 1, "R7", "counters unchanged after done",
        {blen_count, nblk_count}, {12'd1, 12'd1});
    idle_ports();
    @(negedge clk); xfer_active = 0;
    @(negedge clk); xfer_active = 1;
    @(negedge clk);
    chk(xfer_done == 0, "R7", "done cleared by new start", xfer_done, 0);
    xfer_active = 0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule